// File: doc/BRIEF.md
# Per-Lane Delay Sweep Calibrator

This block finds a safe sampling delay for every 8-bit data lane of a parallel memory interface. For each calibration phase it steps a shared tap counter across the whole delay range. At each tap it stores a test word in a memory model, reads it back and compares every lane on its own. It does this twice per tap: once with an alternating bit pattern and once with the bitwise inverse of that pattern. A tap counts as good for a lane only when both readbacks match exactly.

Each lane keeps the longest unbroken run of good taps. When the sweep ends, the block records that run's first and last tap and the midpoint between them. It then programs the lane's delay-line select to that midpoint, which leaves equal margin on both sides. Three phases run one after another, and each phase has its own set of delay selects and result registers. A lane fails when its run is empty or shorter than a programmable minimum. When the last phase completes, the block raises `done`, together with `fail` if any lane in any phase failed.

Top module: `lane_sweep_cal`

## Requirements
- R1: After reset, `done`, `fail`, `mem_wr_en`, `mem_rd_en`, `cal_phase`, every `tap_sel` field and every `lane_fail` bit are 0.
- R2: At every tap the block writes a word with byte 0x55 in every lane and reads it back. It then writes a word with byte 0xAA in every lane and reads it back. A read always comes in the cycle directly after its write, and write and read are never active in the same cycle.
- R3: A tap passes for a lane only when both readbacks of that tap return the written byte unchanged in that lane. A tap where only the 0x55 readback matches counts as failing.
- R4: The window of a lane is its longest contiguous run of passing taps. When two runs have equal length, the run that starts at the lower tap wins.
- R5: For a passing lane, `res_left` holds the first tap of the window, `res_right` holds the last tap, and `res_centre` holds (left+right)/2 rounded down. The lane's `tap_sel` field is then set to the centre value.
- R6: A lane whose window is empty or shorter than `min_width` taps sets its `lane_fail` bit. Its left, right and centre results are 0 and its `tap_sel` field is 0. A window exactly `min_width` long passes.
- R7: Phases run in order 0, 1, 2. Only the `tap_sel` fields of the current phase move during a sweep. The fields of every other phase hold their values, so completed phases keep their programmed centres.
- R8: Within a phase, the sweep visits taps 0 to TAPS-1 in ascending order. All lanes of that phase carry the same tap while the sweep runs.
- R9: When all phases are finished, `done` goes to 1 and stays at 1 until the next accepted `start`. At that point `fail` equals the OR of all `lane_fail` bits.
- R10: A `start` pulse that arrives while a calibration is running has no effect. The run continues in its current phase and produces the same results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a calibration when idle or done |
| min_width | input | 6 | Minimum passing window width in taps |
| done | output | 1 | All phases finished |
| fail | output | 1 | At least one lane failed (valid with done) |
| cal_phase | output | 2 | Phase currently being swept |
| tap_sel | output | 60 | Delay select, 5 bits per lane per phase, field (phase*4+lane) |
| mem_wr_en | output | 1 | Write strobe toward memory model |
| mem_wr_data | output | 32 | Test word, 8 bits per lane |
| mem_rd_en | output | 1 | Read strobe toward memory model |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data, 8 bits per lane |
| res_left | output | 60 | Window first tap per lane per phase |
| res_right | output | 60 | Window last tap per lane per phase |
| res_centre | output | 60 | Chosen centre per lane per phase |
| lane_fail | output | 12 | Fail bit per lane per phase, bit phase*4+lane |

## Verification
The embedded properties are evaluated on every clock cycle. They cover the following:
- write and read are never active together, and each read follows its write;
- a `start` pulse does not disturb a running phase;
- the best window recorded for a lane never shrinks within a sweep and never runs past the last tap;
- a stored centre always lies between its stored edges;
- the `tap_sel` fields of phases that are not being swept stay frozen;
- `fail` agrees with the lane fail bits whenever `done` is high.

Other behaviour can only be shown by the directed scenarios. These include choosing the longest run and breaking ties, rejecting taps that pass only one pattern, treating a window exactly at the minimum width as passing, the windows that sit against tap 0 and the last tap, the actual centre values, and the ascending tap order with its alternating patterns. For these, the bench compares against windows it computes itself from the pass maps it feeds the memory model.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_WAIT,
    ST_EVAL,
    ST_FINAL,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/lsc_window_tracker.sv
module lsc_window_tracker #(
  parameter int TAPS  = 32,
  localparam int TAP_W = $clog2(TAPS),
  localparam int LEN_W = TAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] best_start,
  output logic [LEN_W-1:0] best_len
);
  logic [TAP_W-1:0] cur_start_q, cur_start_d;
  logic [LEN_W-1:0] cur_len_q, cur_len_d;
  logic [TAP_W-1:0] best_start_q, best_start_d;
  logic [LEN_W-1:0] best_len_q, best_len_d;
  logic [LEN_W-1:0] run_len;
  logic [TAP_W-1:0] run_start;

  always_comb begin
    run_len      = cur_len_q + LEN_W'(1);
    run_start    = (cur_len_q == '0) ? tap : cur_start_q;
    cur_start_d  = cur_start_q;
    cur_len_d    = cur_len_q;
    best_start_d = best_start_q;
    best_len_d   = best_len_q;
    if (clear) begin
      cur_start_d  = '0;
      cur_len_d    = '0;
      best_start_d = '0;
      best_len_d   = '0;
    end else if (upd) begin
      if (pass) begin
        cur_start_d = run_start;
        cur_len_d   = run_len;
        if (run_len > best_len_q) begin
          best_start_d = run_start;
          best_len_d   = run_len;
        end
      end else begin
        cur_len_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (clear || upd) begin
      cur_start_q  <= cur_start_d;
      cur_len_q    <= cur_len_d;
      best_start_q <= best_start_d;
      best_len_q   <= best_len_d;
    end
  end

  assign best_start = best_start_q;
  assign best_len   = best_len_q;

  AST_BEST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (LEN_W'(best_start_q) + best_len_q) <= LEN_W'(TAPS)); // R4
  AST_BEST_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clear) |=> (best_len_q >= $past(best_len_q))); // R4
endmodule

// File: rtl/lsc_sequencer.sv
module lsc_sequencer
  import lsc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int TAPS   = 32,
  parameter int PHASES = 3,
  localparam int TAP_W = $clog2(TAPS),
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_valid,
  input  logic [LANES-1:0] lane_match,
  output logic             busy,
  output logic             launch,
  output logic             wr_en,
  output logic             rd_en,
  output logic             pat_sel,
  output logic [TAP_W-1:0] tap,
  output logic [PH_W-1:0]  phase,
  output logic             upd,
  output logic [LANES-1:0] pass_vec,
  output logic             finalize,
  output logic             done
);
  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAPS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASES - 1);

  cal_state_e       state_q, state_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             pat_q, pat_d;
  logic [LANES-1:0] acc_q, acc_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    tap_d   = tap_q;
    pat_d   = pat_q;
    acc_d   = acc_q;
    launch  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          launch  = 1'b1;
          state_d = ST_WR;
          phase_d = '0;
          tap_d   = '0;
          pat_d   = 1'b0;
          acc_d   = '1;
        end
      end
      ST_WR: state_d = ST_RD;
      ST_RD: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid) begin
          acc_d = acc_q & lane_match;
          if (!pat_q) begin
            pat_d   = 1'b1;
            state_d = ST_WR;
          end else begin
            state_d = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        pat_d = 1'b0;
        acc_d = '1;
        if (tap_q == TAP_LAST) begin
          state_d = ST_FINAL;
        end else begin
          tap_d   = tap_q + TAP_W'(1);
          state_d = ST_WR;
        end
      end
      ST_FINAL: begin
        tap_d = '0;
        if (phase_q == PH_LAST) begin
          state_d = ST_DONE;
        end else begin
          phase_d = phase_q + PH_W'(1);
          state_d = ST_WR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      tap_q   <= '0;
      pat_q   <= 1'b0;
      acc_q   <= '1;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      tap_q   <= tap_d;
      pat_q   <= pat_d;
      acc_q   <= acc_d;
    end
  end

  assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign wr_en    = (state_q == ST_WR);
  assign rd_en    = (state_q == ST_RD);
  assign upd      = (state_q == ST_EVAL);
  assign finalize = (state_q == ST_FINAL);
  assign done     = (state_q == ST_DONE);
  assign pat_sel  = pat_q;
  assign tap      = tap_q;
  assign phase    = phase_q;
  assign pass_vec = acc_q;

  AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R2
  AST_READ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $past(wr_en)); // R2
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finalize) |=> (phase == $past(phase))); // R10
endmodule

// File: rtl/lane_sweep_cal.sv
module lane_sweep_cal #(
  parameter int          LANES    = 4,
  parameter int          LANE_W   = 8,
  parameter int          TAPS     = 32,
  parameter int          PHASES   = 3,
  parameter logic [7:0]  PAT_BYTE = 8'h55,
  localparam int TAP_W = $clog2(TAPS),
  localparam int LEN_W = TAP_W + 1,
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int SLOTS = PHASES * LANES,
  localparam int DW    = LANES * LANE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LEN_W-1:0]       min_width,
  output logic                   done,
  output logic                   fail,
  output logic [PH_W-1:0]        cal_phase,
  output logic [SLOTS*TAP_W-1:0] tap_sel,
  output logic                   mem_wr_en,
  output logic [DW-1:0]          mem_wr_data,
  output logic                   mem_rd_en,
  input  logic                   mem_rd_valid,
  input  logic [DW-1:0]          mem_rd_data,
  output logic [SLOTS*TAP_W-1:0] res_left,
  output logic [SLOTS*TAP_W-1:0] res_right,
  output logic [SLOTS*TAP_W-1:0] res_centre,
  output logic [SLOTS-1:0]       lane_fail
);
  localparam logic [LANE_W-1:0] PAT_A = LANE_W'(PAT_BYTE);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_int <= rst_s1;
    end
  end

  logic             busy, launch, pat_sel, upd, finalize, seq_done;
  logic [TAP_W-1:0] sweep_tap;
  logic [PH_W-1:0]  phase;
  logic [LANES-1:0] lane_match, pass_vec;
  logic             trk_clear;
  logic [LANE_W-1:0] lane_pat;

  assign trk_clear = launch | finalize;
  assign lane_pat  = pat_sel ? ~PAT_A : PAT_A;

  lsc_sequencer #(.LANES(LANES), .TAPS(TAPS), .PHASES(PHASES)) u_seq (
    .clk(clk), .rst_n(rst_int), .start(start), .rd_valid(mem_rd_valid),
    .lane_match(lane_match), .busy(busy), .launch(launch), .wr_en(mem_wr_en),
    .rd_en(mem_rd_en), .pat_sel(pat_sel), .tap(sweep_tap), .phase(phase),
    .upd(upd), .pass_vec(pass_vec), .finalize(finalize), .done(seq_done)
  );

  logic [TAP_W-1:0] win_left   [LANES];
  logic [TAP_W-1:0] win_right  [LANES];
  logic [TAP_W-1:0] win_centre [LANES];
  logic [LANES-1:0] win_bad;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TAP_W-1:0] bstart;
    logic [LEN_W-1:0] blen, right_ext, sum_ext;

    assign mem_wr_data[l*LANE_W +: LANE_W] = lane_pat;
    assign lane_match[l] = (mem_rd_data[l*LANE_W +: LANE_W] == lane_pat);

    lsc_window_tracker #(.TAPS(TAPS)) u_trk (
      .clk(clk), .rst_n(rst_int), .clear(trk_clear), .upd(upd),
      .pass(pass_vec[l]), .tap(sweep_tap), .best_start(bstart), .best_len(blen)
    );

    always_comb begin
      right_ext     = LEN_W'(bstart) + blen - LEN_W'(1);
      sum_ext       = LEN_W'(bstart) + LEN_W'(right_ext[TAP_W-1:0]);
      win_bad[l]    = (blen == '0) || (blen < min_width);
      win_left[l]   = win_bad[l] ? '0 : bstart;
      win_right[l]  = win_bad[l] ? '0 : right_ext[TAP_W-1:0];
      win_centre[l] = win_bad[l] ? '0 : sum_ext[LEN_W-1:1];
    end
  end

  logic [TAP_W-1:0] left_q   [SLOTS];
  logic [TAP_W-1:0] right_q  [SLOTS];
  logic [TAP_W-1:0] centre_q [SLOTS];
  logic [SLOTS-1:0] lfail_q;
  logic             fail_q, fail_d;

  always_comb begin
    fail_d = fail_q;
    if (launch)        fail_d = 1'b0;
    else if (finalize) fail_d = fail_q | (|win_bad);
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      fail_q <= 1'b0;
    end else if (launch || finalize) begin
      fail_q <= fail_d;
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_ph
    logic wr_slot;
    assign wr_slot = finalize && (phase == PH_W'(p));
    for (genvar l = 0; l < LANES; l++) begin : g_sl
      localparam int S = p * LANES + l;
      always_ff @(posedge clk or negedge rst_int) begin
        if (!rst_int) begin
          left_q[S]   <= '0;
          right_q[S]  <= '0;
          centre_q[S] <= '0;
          lfail_q[S]  <= 1'b0;
        end else if (wr_slot) begin
          left_q[S]   <= win_left[l];
          right_q[S]  <= win_right[l];
          centre_q[S] <= win_centre[l];
          lfail_q[S]  <= win_bad[l];
        end
      end
      assign tap_sel[S*TAP_W +: TAP_W]    = (busy && phase == PH_W'(p)) ? sweep_tap : centre_q[S];
      assign res_left[S*TAP_W +: TAP_W]   = left_q[S];
      assign res_right[S*TAP_W +: TAP_W]  = right_q[S];
      assign res_centre[S*TAP_W +: TAP_W] = centre_q[S];

      AST_CENTRE_INSIDE: assert property (@(posedge clk) disable iff (!rst_int)
        !lfail_q[S] |-> (left_q[S] <= centre_q[S] && centre_q[S] <= right_q[S])); // R5
      AST_IDLE_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_int)
        (busy && $past(busy) && phase != PH_W'(p) && $past(phase) != PH_W'(p))
          |-> $stable(tap_sel[S*TAP_W +: TAP_W])); // R7
    end
  end

  assign lane_fail = lfail_q;
  assign fail      = fail_q;
  assign done      = seq_done;
  assign cal_phase = phase;

  AST_FAIL_MATCHES_LANES: assert property (@(posedge clk) disable iff (!rst_int)
    done |-> (fail == (|lane_fail))); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_int)
    (done && !start) |=> done); // R9
endmodule

// File: tb/tb_lane_sweep_cal.sv
`timescale 1ns/1ps
module tb_lane_sweep_cal;
  localparam int LANES = 4, TAPS = 32, PHASES = 3, TAP_W = 5, SLOTS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] min_width = 6'd4;
  logic done, fail, mem_wr_en, mem_rd_en;
  logic [1:0] cal_phase;
  logic [SLOTS*TAP_W-1:0] tap_sel, res_left, res_right, res_centre;
  logic [31:0] mem_wr_data;
  logic [31:0] mem_rd_data = '0;
  logic mem_rd_valid = 1'b0;
  logic [SLOTS-1:0] lane_fail;

  always #2 clk = ~clk;

  lane_sweep_cal dut (
    .clk(clk), .rst_n(rst_n), .start(start), .min_width(min_width),
    .done(done), .fail(fail), .cal_phase(cal_phase), .tap_sel(tap_sel),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .mem_rd_en(mem_rd_en),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .res_left(res_left), .res_right(res_right), .res_centre(res_centre),
    .lane_fail(lane_fail)
  );

  int n_chk = 0, n_bad = 0;
  logic [TAPS-1:0] pm [PHASES][LANES];
  logic [TAPS-1:0] sm [PHASES][LANES];

  // memory model: one stored word, read answer two edges after the strobe
  logic [31:0] stored = '0;
  logic rd_pend = 1'b0;
  int wcnt = 0, rcnt = 0, err_r2 = 0, err_r8 = 0, err_r7 = 0;

  function automatic logic [4:0] tsel(input int p, input int l);
    return tap_sel[(p*LANES+l)*TAP_W +: TAP_W];
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= rd_pend;
    rd_pend <= mem_rd_en;
    if (rd_pend) begin
      for (int l = 0; l < LANES; l++) begin
        logic [7:0] b;
        b = stored[l*8 +: 8];
        if (!pm[cal_phase][l][tsel(cal_phase, l)])
          b = sm[cal_phase][l][tsel(cal_phase, l)] ? 8'h55 : (b ^ 8'h0F);
        mem_rd_data[l*8 +: 8] <= b;
      end
    end
    if (mem_wr_en) begin
      stored <= mem_wr_data;
      if (mem_wr_data != ((wcnt % 2) ? 32'hAAAA_AAAA : 32'h5555_5555)) err_r2++;
      wcnt++;
    end
    if (mem_rd_en) begin
      if (int'(cal_phase) != rcnt / (2*TAPS)) err_r8++;
      for (int l = 0; l < LANES; l++)
        if (int'(tsel(cal_phase, l)) != (rcnt % (2*TAPS)) / 2) err_r8++;
      for (int q = 0; q < PHASES; q++)
        for (int l = 0; l < LANES; l++)
          if (q < int'(cal_phase) && tsel(q, l) != res_centre[(q*LANES+l)*TAP_W +: TAP_W]) err_r7++;
      rcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] win(input int lo, input int hi);
    logic [TAPS-1:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return m;
  endfunction

  task automatic best_run(input logic [TAPS-1:0] m, output int lo, output int len);
    int cs = 0, cl = 0;
    lo = 0; len = 0;
    for (int t = 0; t < TAPS; t++) begin
      if (m[t]) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > len) begin len = cl; lo = cs; end
      end else cl = 0;
    end
  endtask

  task automatic run_cal(input bool_dummy_t_unused = 0);
  endtask

  task automatic launch_and_wait(input bit poke_midrun);
    int cyc = 0;
    wcnt = 0; rcnt = 0; err_r2 = 0; err_r8 = 0; err_r7 = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_midrun) begin
      while (cal_phase != 2'd1) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      // R10: pulse during phase 1 must not restart the sweep
      chk(cal_phase == 2'd1 && !done, "R10", "phase after mid-run start", cal_phase, 1);
    end
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done, "R9", "done reached", done, 1);
  endtask

  task automatic check_results(input string tag);
    bit any_fail = 0;
    for (int p = 0; p < PHASES; p++)
      for (int l = 0; l < LANES; l++) begin
        int lo, len, el, er, ec, s;
        bit ef;
        s = (p*LANES+l)*TAP_W;
        best_run(pm[p][l], lo, len);
        ef = (len == 0) || (len < int'(min_width));
        el = ef ? 0 : lo; er = ef ? 0 : lo + len - 1; ec = ef ? 0 : (el + er) / 2;
        any_fail |= ef;
        chk(lane_fail[p*LANES+l] == ef, "R6", {tag, " lane_fail"}, lane_fail[p*LANES+l], ef);
        chk(int'(res_left[s +: TAP_W]) == el, "R4", {tag, " left"}, res_left[s +: TAP_W], el);
        chk(int'(res_right[s +: TAP_W]) == er, "R4", {tag, " right"}, res_right[s +: TAP_W], er);
        chk(int'(res_centre[s +: TAP_W]) == ec, "R5", {tag, " centre"}, res_centre[s +: TAP_W], ec);
        chk(int'(tap_sel[s +: TAP_W]) == ec, "R5", {tag, " tap_sel"}, tap_sel[s +: TAP_W], ec);
      end
    chk(fail == any_fail, "R9", {tag, " overall fail"}, fail, any_fail);
    chk(err_r2 == 0 && wcnt == PHASES*TAPS*2, "R2", {tag, " write patterns"}, err_r2, 0);
    chk(err_r8 == 0 && rcnt == PHASES*TAPS*2, "R8", {tag, " tap order"}, err_r8, 0);
    chk(err_r7 == 0, "R7", {tag, " finished phases hold"}, err_r7, 0);
  endtask

  task automatic t_reset;
    chk(!done && !fail && !mem_wr_en && !mem_rd_en, "R1", "control outputs", {done, fail, mem_wr_en, mem_rd_en}, 0);
    chk(tap_sel == '0 && cal_phase == '0, "R1", "tap_sel and phase", tap_sel, 0);
    chk(lane_fail == '0, "R1", "lane_fail", lane_fail, 0);
  endtask

  task automatic t_basic;
    min_width = 6'd4;
    for (int p = 0; p < PHASES; p++)
      for (int l = 0; l < LANES; l++) begin
        pm[p][l] = win(3 + l + p, 12 + 2*l + p); sm[p][l] = '0;
      end
    launch_and_wait(0);
    check_results("basic");
    repeat (20) @(negedge clk);
    chk(done, "R9", "done held", done, 1);
  endtask

  task automatic t_regions;
    min_width = 6'd1;
    for (int p = 0; p < PHASES; p++) begin
      pm[p][0] = win(2, 5) | win(10, 13);           // R4 tie: lower start wins
      pm[p][1] = win(0, 2) | win(20, 27) | win(29, 29);
      pm[p][2] = '1;                                // full range
      pm[p][3] = win(28, 31) | win(p, p);           // against last tap
      for (int l = 0; l < LANES; l++) sm[p][l] = '0;
    end
    launch_and_wait(0);
    check_results("regions");
  endtask

  task automatic t_failing;
    min_width = 6'd4;
    for (int p = 0; p < PHASES; p++) begin
      pm[p][0] = '0;                                 // R6 nothing passes
      pm[p][1] = win(8, 10);                         // R6 below minimum
      pm[p][2] = win(14 + p, 17 + p);                // R6 exactly minimum
      pm[p][3] = win(10, 15);                        // R3 only inverse fails outside
      for (int l = 0; l < LANES; l++) sm[p][l] = (l == 3) ? '1 : '0;
    end
    launch_and_wait(0);
    check_results("failing");
  endtask

  task automatic t_midrun_start;
    min_width = 6'd4;
    for (int p = 0; p < PHASES; p++)
      for (int l = 0; l < LANES; l++) begin
        pm[p][l] = win(5 + 2*l, 20 - p); sm[p][l] = '0;
      end
    launch_and_wait(1);
    // R10: results equal those of an undisturbed run
    check_results("midrun");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    for (int p = 0; p < PHASES; p++)
      for (int l = 0; l < LANES; l++) begin pm[p][l] = '0; sm[p][l] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_regions;
    t_failing;
    t_midrun_start;
    summary;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule